// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block is an 8 KB data cache with two ways per set, 32-byte lines and a 34-bit byte address. A client issues one 64-bit load or store at a time. The cache checks the tags of both ways of the selected set in parallel, and the way that matches steers its data to the response through a multiplexer. Stores change only the cached copy and mark the line as modified. A store miss first fetches the line and then writes into it.

On a miss the cache picks a victim in the set. If the victim line is modified, it is first streamed to memory as four 64-bit beats. The missing line is then requested and received as four beats. The cache finally repeats the lookup, which now hits and completes the original access. One bit per set records which way to replace next.

The client side and the memory side are valid/ready channels. A transfer happens on a clock edge where both valid and ready are high. A source holds valid and its payload steady until the transfer happens. The cache accepts a new request only after the previous response has been taken. It holds its response for as long as `rsp_ready` stays low. While memory withholds ready, the cache holds each writeback beat, together with its address, and the refill request steady. The cache is always ready for refill data while it waits for it.

Top module: `wbc_cache`

## Requirements
- R1: `req_ready` is high only when no access is in flight. After a request is accepted, `req_ready` stays low until the response has been taken. `rsp_valid` and `rsp_rdata` stay unchanged while `rsp_ready` is low.
- R2: Address bits [2:0] are ignored. Bits [4:3] select the 64-bit word in the line (word 0 first), bits [11:5] select one of 128 sets, and bits [33:12] form the tag. Two lines with the same set bits and different tags can be resident together.
- R3: A load that hits returns the most recently stored value of that word and causes no memory traffic. Traffic occurs only between acceptance of a request and its response.
- R4: A store that hits updates only the cached word and marks the line modified. A store response returns the stored value.
- R5: On a miss the victim is way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the way named by the set's replacement bit. Every hit and every fill sets that bit to the way not accessed.
- R6: A modified victim is written back as exactly four beats, words 0 to 3 in order, on the line address {victim tag, set}, with `mem_wb_last` high on the fourth beat only. An unmodified victim causes no writeback.
- R7: The refill request carries the line address {request tag, set}. It is issued only after the writeback, if any, has finished, and only once per miss. Its four data beats fill words 0 to 3 in order.
- R8: A store miss allocates the line and merges the store into the refilled data. A later eviction of that line writes back the merged line.
- R9: Reset clears all valid, modified and replacement bits. Right after reset no request is in flight, and the first access to any set misses without a writeback.
- R10: While `mem_wb_ready` is low, a pending writeback beat keeps its data and address. While `mem_rf_req_ready` is low, a pending refill request keeps its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 34 | Byte address |
| req_wdata | input | 64 | Store data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Client takes the response |
| rsp_rdata | output | 64 | Load data, or the stored value for a store |
| mem_wb_valid | output | 1 | Writeback beat valid |
| mem_wb_ready | input | 1 | Memory takes the writeback beat |
| mem_wb_addr | output | 29 | Line address of the line being written back |
| mem_wb_data | output | 64 | Writeback beat data |
| mem_wb_last | output | 1 | Fourth beat of the writeback |
| mem_rf_req_valid | output | 1 | Refill request valid |
| mem_rf_req_ready | input | 1 | Memory takes the refill request |
| mem_rf_addr | output | 29 | Line address to refill |
| mem_rf_valid | input | 1 | Refill beat valid |
| mem_rf_ready | output | 1 | Cache takes the refill beat |
| mem_rf_data | input | 64 | Refill beat data |

## Verification
Wrong tag, valid or modified state shows up only on a later access to the same set. It appears as a wrong load value, a refill for a line that should have hit, a writeback that should not happen, or a missing writeback. A wrong replacement bit shows one or two accesses later, as a writeback or refill on the wrong line address. For that reason a reference model tracks every set and checks the address and data of each memory beat as it happens. Corrupted line data stays hidden until that word is loaded, or until the line is evicted and its writeback beats are compared.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  parameter int ADDR_W     = 34;
  parameter int DATA_W     = 64;
  parameter int LINE_BYTES = 32;
  parameter int NUM_SETS   = 128;

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int BEATS      = LINE_BYTES / WORD_BYTES;
  localparam int BYTE_W     = $clog2(WORD_BYTES);
  localparam int BEAT_W     = $clog2(BEATS);
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int IDX_W      = $clog2(NUM_SETS);
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W     = ADDR_W - OFF_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_WBACK, ST_RFREQ, ST_RFILL, ST_RESP
  } cst_t;
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store
  import wbc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      idx,
  input  logic [TAG_W-1:0]      tag_in,
  input  logic                  fill_en,
  input  logic                  fill_way,
  input  logic                  dirty_en,
  input  logic                  dirty_way,
  input  logic                  touch_en,
  input  logic                  touch_way,
  output logic [1:0]            hit,
  output logic [1:0]            valid_o,
  output logic [1:0]            dirty_o,
  output logic [1:0][TAG_W-1:0] tag_o,
  output logic                  lru_o
);
  logic [NUM_SETS-1:0] lru_bits;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0]    tag_mem [NUM_SETS];
    logic [NUM_SETS-1:0] vld;
    logic [NUM_SETS-1:0] drt;

    always_ff @(posedge clk) begin
      if (fill_en && fill_way == 1'(w)) tag_mem[idx] <= tag_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld <= '0;
        drt <= '0;
      end else if (fill_en && fill_way == 1'(w)) begin
        vld[idx] <= 1'b1;
        drt[idx] <= 1'b0;
      end else if (dirty_en && dirty_way == 1'(w)) begin
        drt[idx] <= 1'b1;
      end
    end

    assign valid_o[w] = vld[idx];
    assign dirty_o[w] = drt[idx];
    assign tag_o[w]   = tag_mem[idx];
    assign hit[w]     = vld[idx] && (tag_mem[idx] == tag_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lru_bits <= '0;
    else if (touch_en) lru_bits[idx] <= ~touch_way;
  end

  assign lru_o = lru_bits[idx];
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store
  import wbc_pkg::*;
(
  input  logic                   clk,
  input  logic [IDX_W-1:0]       idx,
  input  logic [BEAT_W-1:0]      word,
  input  logic                   we,
  input  logic                   we_way,
  input  logic [DATA_W-1:0]      wdata,
  output logic [1:0][DATA_W-1:0] rdata
);
  localparam int DEPTH = NUM_SETS * BEATS;

  logic [$clog2(DEPTH)-1:0] slot;
  assign slot = {idx, word};

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && we_way == 1'(w)) mem[slot] <= wdata;
    end
    assign rdata[w] = mem[slot];
  end
endmodule

// File: rtl/wbc_victim_pick.sv
module wbc_victim_pick (
  input  logic [1:0] valid,
  input  logic       lru,
  output logic       victim
);
  always_comb begin
    if (!valid[0])      victim = 1'b0;
    else if (!valid[1]) victim = 1'b1;
    else                victim = lru;
  end
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
  import wbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_wb_valid,
  input  logic              mem_wb_ready,
  output logic [LINE_W-1:0] mem_wb_addr,
  output logic [DATA_W-1:0] mem_wb_data,
  output logic              mem_wb_last,
  output logic              mem_rf_req_valid,
  input  logic              mem_rf_req_ready,
  output logic [LINE_W-1:0] mem_rf_addr,
  input  logic              mem_rf_valid,
  output logic              mem_rf_ready,
  input  logic [DATA_W-1:0] mem_rf_data
);
  cst_t st;
  logic                   q_write;
  logic [ADDR_W-1:BYTE_W] q_addr;
  logic [DATA_W-1:0]      q_wdata;
  logic                   vic_q;
  logic [BEAT_W-1:0]      beat_q;
  logic [DATA_W-1:0]      rsp_q;

  logic unused_byte_bits;
  assign unused_byte_bits = ^req_addr[BYTE_W-1:0];

  logic [IDX_W-1:0]  q_idx;
  logic [TAG_W-1:0]  q_tag;
  logic [BEAT_W-1:0] q_word;
  assign q_idx  = q_addr[OFF_W +: IDX_W];
  assign q_tag  = q_addr[ADDR_W-1 -: TAG_W];
  assign q_word = q_addr[BYTE_W +: BEAT_W];

  logic [1:0]              hit, way_vld, way_drt;
  logic [1:0][TAG_W-1:0]   way_tag;
  logic [1:0][DATA_W-1:0]  way_data;
  logic                    set_lru, vic_now, hit_any, hit_way, beat_last;
  logic                    fill_en, dirty_en, touch_en, touch_way;
  logic                    d_we, d_way;
  logic [BEAT_W-1:0]       word_sel;
  logic [DATA_W-1:0]       d_wdata;

  assign hit_any   = |hit;
  assign hit_way   = hit[1];
  assign beat_last = (beat_q == BEAT_W'(BEATS - 1));

  always_comb begin
    word_sel  = (st == ST_LOOK) ? q_word : beat_q;
    d_we      = (st == ST_LOOK && hit_any && q_write) || (st == ST_RFILL && mem_rf_valid);
    d_way     = (st == ST_LOOK) ? hit_way : vic_q;
    d_wdata   = (st == ST_LOOK) ? q_wdata : mem_rf_data;
    fill_en   = (st == ST_RFILL) && mem_rf_valid && beat_last;
    dirty_en  = (st == ST_LOOK) && hit_any && q_write;
    touch_en  = fill_en || ((st == ST_LOOK) && hit_any);
    touch_way = (st == ST_LOOK) ? hit_way : vic_q;
  end

  wbc_tag_store u_tags (
    .clk(clk), .rst_n(rst_n), .idx(q_idx), .tag_in(q_tag),
    .fill_en(fill_en), .fill_way(vic_q),
    .dirty_en(dirty_en), .dirty_way(hit_way),
    .touch_en(touch_en), .touch_way(touch_way),
    .hit(hit), .valid_o(way_vld), .dirty_o(way_drt),
    .tag_o(way_tag), .lru_o(set_lru)
  );

  wbc_data_store u_data (
    .clk(clk), .idx(q_idx), .word(word_sel), .we(d_we), .we_way(d_way),
    .wdata(d_wdata), .rdata(way_data)
  );

  wbc_victim_pick u_pick (.valid(way_vld), .lru(set_lru), .victim(vic_now));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      q_write <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
      vic_q   <= 1'b0;
      beat_q  <= '0;
      rsp_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          q_write <= req_write;
          q_addr  <= req_addr[ADDR_W-1:BYTE_W];
          q_wdata <= req_wdata;
          st      <= ST_LOOK;
        end
        ST_LOOK: if (hit_any) begin
          rsp_q <= q_write ? q_wdata : way_data[hit_way];
          st    <= ST_RESP;
        end else begin
          vic_q  <= vic_now;
          beat_q <= '0;
          st     <= (way_vld[vic_now] && way_drt[vic_now]) ? ST_WBACK : ST_RFREQ;
        end
        ST_WBACK: if (mem_wb_ready) begin
          beat_q <= beat_q + 1'b1;
          if (beat_last) st <= ST_RFREQ;
        end
        ST_RFREQ: if (mem_rf_req_ready) begin
          beat_q <= '0;
          st     <= ST_RFILL;
        end
        ST_RFILL: if (mem_rf_valid) begin
          beat_q <= beat_q + 1'b1;
          if (beat_last) st <= ST_LOOK;
        end
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready        = (st == ST_IDLE);
  assign rsp_valid        = (st == ST_RESP);
  assign rsp_rdata        = rsp_q;
  assign mem_wb_valid     = (st == ST_WBACK);
  assign mem_wb_addr      = {way_tag[vic_q], q_idx};
  assign mem_wb_data      = way_data[vic_q];
  assign mem_wb_last      = beat_last;
  assign mem_rf_req_valid = (st == ST_RFREQ);
  assign mem_rf_addr      = {q_tag, q_idx};
  assign mem_rf_ready     = (st == ST_RFILL);
endmodule

// File: rtl/wbc_cache_chk.sv
module wbc_cache_chk
  import wbc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              mem_wb_valid,
  input logic              mem_wb_ready,
  input logic [LINE_W-1:0] mem_wb_addr,
  input logic [DATA_W-1:0] mem_wb_data,
  input logic              mem_wb_last,
  input logic              mem_rf_req_valid,
  input logic              mem_rf_req_ready,
  input logic [LINE_W-1:0] mem_rf_addr
);
  logic            pending;
  logic [BEAT_W:0] wb_cnt;
  logic [1:0]      rf_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      wb_cnt  <= '0;
      rf_cnt  <= '0;
    end else begin
      if (req_valid && req_ready) begin
        pending <= 1'b1;
        wb_cnt  <= '0;
        rf_cnt  <= '0;
      end else begin
        if (rsp_valid && rsp_ready) pending <= 1'b0;
        if (mem_wb_valid && mem_wb_ready) wb_cnt <= wb_cnt + 1'b1;
        if (mem_rf_req_valid && mem_rf_req_ready) rf_cnt <= rf_cnt + 1'b1;
      end
    end
  end

  a_r1_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !req_ready);

  a_r1_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  a_r3_traffic_only_in_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> !mem_wb_valid && !mem_rf_req_valid);

  a_r6_last_on_fourth: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wb_valid |-> (mem_wb_last == (wb_cnt == (BEAT_W+1)'(BEATS - 1))));

  a_r7_wb_before_refill: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rf_req_valid |-> (wb_cnt == '0 || wb_cnt == (BEAT_W+1)'(BEATS)));

  a_r7_one_refill: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rf_req_valid |-> rf_cnt == 2'd0);

  a_r10_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wb_valid && !mem_wb_ready |=>
      mem_wb_valid && $stable(mem_wb_addr) && $stable(mem_wb_data));

  a_r10_rf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rf_req_valid && !mem_rf_req_ready |=> mem_rf_req_valid && $stable(mem_rf_addr));
endmodule

bind wbc_cache wbc_cache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .mem_wb_valid(mem_wb_valid), .mem_wb_ready(mem_wb_ready),
  .mem_wb_addr(mem_wb_addr), .mem_wb_data(mem_wb_data), .mem_wb_last(mem_wb_last),
  .mem_rf_req_valid(mem_rf_req_valid), .mem_rf_req_ready(mem_rf_req_ready),
  .mem_rf_addr(mem_rf_addr)
);

// File: tb/wbc_cache_bench.sv
`timescale 1ns/1ps
module wbc_cache_bench;
  import wbc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid, rsp_ready = 1'b0;
  logic [DATA_W-1:0] rsp_rdata;
  logic              mem_wb_valid, mem_wb_ready = 1'b0, mem_wb_last;
  logic [LINE_W-1:0] mem_wb_addr;
  logic [DATA_W-1:0] mem_wb_data;
  logic              mem_rf_req_valid, mem_rf_req_ready = 1'b0;
  logic [LINE_W-1:0] mem_rf_addr;
  logic              mem_rf_valid = 1'b0, mem_rf_ready;
  logic [DATA_W-1:0] mem_rf_data = '0;

  wbc_cache u_wbc_cache (.*);

  int n_chk = 0, n_err = 0, cyc = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // bench memory: written lines kept, others follow a fixed pattern
  logic [63:0] bmem [bit [LINE_W+BEAT_W-1:0]];
  function automatic logic [63:0] mem_rd(input logic [LINE_W-1:0] line, input int b);
    bit [LINE_W+BEAT_W-1:0] k = {line, BEAT_W'(b)};
    if (bmem.exists(k)) return bmem[k];
    return {line, 3'(b), 32'hC0DE_0000 ^ 32'(line)};
  endfunction

  // reference model of the cache contents
  bit                m_val [2][NUM_SETS];
  bit                m_drt [2][NUM_SETS];
  logic [TAG_W-1:0]  m_tag [2][NUM_SETS];
  bit                m_lru [NUM_SETS];
  logic [63:0]       m_dat [2][NUM_SETS][BEATS];

  // per-access expectations and observations
  bit                e_wb, e_rf;
  logic [LINE_W-1:0] e_wb_addr, e_rf_addr;
  logic [63:0]       e_wb_data [BEATS];
  int                o_wb, o_rf;

  // memory responder
  logic [15:0]       lfsr = 16'hACE1;
  bit                rf_busy = 0;
  logic [LINE_W-1:0] rf_line;
  int                rf_beat;
  bit                wb_stalled = 0;
  logic [LINE_W-1:0] st_addr;
  logic [63:0]       st_data;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
    if (rst_n) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (wb_stalled)  // R10: stalled beat unchanged
        chk(mem_wb_valid && mem_wb_addr == st_addr && mem_wb_data == st_data,
            "R10", "held writeback beat", mem_wb_data, st_data);
      mem_wb_ready     = lfsr[1] | lfsr[4];
      mem_rf_req_ready = lfsr[2] | lfsr[5];
      wb_stalled = mem_wb_valid && !mem_wb_ready;
      st_addr = mem_wb_addr;
      st_data = mem_wb_data;
      if (mem_wb_valid && mem_wb_ready) begin
        chk(e_wb && o_wb < BEATS, "R6", "unexpected writeback beat", 64'(o_wb), 64'(e_wb));
        if (e_wb && o_wb < BEATS) begin
          chk(mem_wb_addr == e_wb_addr, "R6", "writeback address", 64'(mem_wb_addr), 64'(e_wb_addr));
          chk(mem_wb_data == e_wb_data[o_wb], "R6", "writeback data", mem_wb_data, e_wb_data[o_wb]);
          chk(mem_wb_last == (o_wb == BEATS-1), "R6", "last flag", 64'(mem_wb_last), 64'(o_wb == BEATS-1));
        end
        bmem[{mem_wb_addr, BEAT_W'(o_wb)}] = mem_wb_data;
        o_wb++;
      end
      if (rf_busy) begin
        mem_rf_valid = lfsr[6] | lfsr[7];
        mem_rf_data  = mem_rd(rf_line, rf_beat);
        if (mem_rf_valid && mem_rf_ready) begin
          rf_beat++;
          if (rf_beat == BEATS) rf_busy = 0;
        end
      end else begin
        mem_rf_valid = 1'b0;
      end
      if (mem_rf_req_valid && mem_rf_req_ready) begin
        chk(e_rf && o_rf == 0, "R7", "refill request count", 64'(o_rf), 64'(0));
        chk(mem_rf_addr == e_rf_addr, "R7", "refill address", 64'(mem_rf_addr), 64'(e_rf_addr));
        chk(o_wb == (e_wb ? BEATS : 0), "R7", "writeback done before refill", 64'(o_wb), 64'(e_wb ? BEATS : 0));
        o_rf++;
        rf_busy = 1;
        rf_line = mem_rf_addr;
        rf_beat = 0;
      end
    end
  end

  function automatic logic [ADDR_W-1:0] mk(input int tg, input int set, input int w, input int b);
    return {TAG_W'(tg), IDX_W'(set), BEAT_W'(w), BYTE_W'(b)};
  endfunction

  task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [63:0] wd,
                        input string rq, input int hold = 0);
    int set = int'(a[OFF_W +: IDX_W]);
    logic [TAG_W-1:0] tg = a[ADDR_W-1 -: TAG_W];
    int w = int'(a[BYTE_W +: BEAT_W]);
    int hw = -1;
    int t = 0;
    logic [63:0] exp;
    e_wb = 0; e_rf = 0; o_wb = 0; o_rf = 0;
    for (int k = 0; k < 2; k++) if (m_val[k][set] && m_tag[k][set] == tg) hw = k;
    if (hw < 0) begin
      int v = !m_val[0][set] ? 0 : (!m_val[1][set] ? 1 : int'(m_lru[set]));
      if (m_val[v][set] && m_drt[v][set]) begin
        e_wb = 1;
        e_wb_addr = {m_tag[v][set], IDX_W'(set)};
        for (int b = 0; b < BEATS; b++) e_wb_data[b] = m_dat[v][set][b];
      end
      e_rf = 1;
      e_rf_addr = {tg, IDX_W'(set)};
      for (int b = 0; b < BEATS; b++) m_dat[v][set][b] = mem_rd(e_rf_addr, b);
      m_val[v][set] = 1; m_drt[v][set] = 0; m_tag[v][set] = tg;
      hw = v;
    end
    m_lru[set] = (hw == 0);
    if (wr) begin
      m_dat[hw][set][w] = wd;
      m_drt[hw][set] = 1;
    end
    exp = m_dat[hw][set][w];

    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    forever begin
      if (req_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    req_valid = 1'b0;
    rsp_ready = (hold == 0);
    while (!rsp_valid) begin
      @(negedge clk);
      t++;
      if (t > 2000) begin
        chk(0, rq, "response timeout", 64'(t), 64'(0));
        return;
      end
    end
    for (int i = 0; i < hold; i++) begin
      chk(rsp_valid && rsp_rdata == exp, "R1", "response held", rsp_rdata, exp);
      chk(!req_ready, "R1", "no new request while response pending", 64'(req_ready), 64'(0));
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    chk(rsp_rdata == exp, rq, "response data", rsp_rdata, exp);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(o_wb == (e_wb ? BEATS : 0), rq, "writeback beats", 64'(o_wb), 64'(e_wb ? BEATS : 0));
    chk(o_rf == int'(e_rf), rq, "refill requests", 64'(o_rf), 64'(e_rf));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: idle after reset
    chk(req_ready && !rsp_valid && !mem_wb_valid && !mem_rf_req_valid, "R9",
        "idle after reset", {req_ready, rsp_valid, mem_wb_valid, mem_rf_req_valid}, 64'h8);

    access(0, mk(10, 5, 2, 0), 0, "R9");                    // cold miss, way 0
    access(0, mk(10, 5, 1, 0), 0, "R3");                    // hit
    access(1, mk(10, 5, 1, 0), 64'h1111_2222_3333_4444, "R4"); // store hit
    access(0, mk(10, 5, 1, 6), 0, "R2");                    // byte bits ignored
    access(0, mk(20, 5, 0, 0), 0, "R5");                    // fills invalid way 1
    access(0, mk(10, 5, 3, 0), 0, "R2");                    // both tags resident
    access(0, mk(30, 5, 0, 0), 0, "R5");                    // evicts clean way 1
    access(0, mk(40, 5, 0, 0), 0, "R6");                    // evicts modified way 0
    access(1, mk(50, 6, 2, 0), 64'hDEAD_BEEF_0BAD_F00D, "R8"); // store miss allocates
    access(0, mk(50, 6, 2, 0), 0, "R8");
    access(0, mk(51, 6, 0, 0), 0, "R8");
    access(0, mk(52, 6, 0, 0), 0, "R8");                    // merged line written back
    access(0, mk(40, 5, 1, 0), 0, "R1", 5);                 // response back-pressure
    access(1, mk(30, 5, 3, 0), 64'h5A5A, "R1", 3);

    for (int n = 0; n < 400; n++) begin
      int sets[3] = '{0, 1, NUM_SETS-1};
      access(1'($urandom_range(0, 1)),
             mk($urandom_range(0, 5), sets[$urandom_range(0, 2)], $urandom_range(0, 3), $urandom_range(0, 7)),
             {$urandom, $urandom}, "R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule